// File: doc/BRIEF.md
# Word RAM with Switch-Loaded Ports and an Output Register

This block is the whole memory system behind a small 32-bit processor. The processor presents a byte address, write data and separate read and write strobes. The block returns read data one cycle after a read strobe. Low addresses reach a 256-word RAM. Two fixed addresses near the top of a 64 KiB window return two input registers. The upper of those two addresses, when written, drives a 32-bit output register instead.

The two input registers are loaded from the board and not by the processor. Nine data switches are shared by both registers, and a tenth switch picks which register is loaded. A push-button, synchronised and edge-detected inside the block, triggers one load per press. The loaded value is the nine switch bits with zeros above them.

The processor reset clears the output register and the read path. It leaves the input registers as they are, so a program can be restarted against newly entered values.

Top module: `mem_io_sys`

## Requirements
- R1: The RAM holds 256 words of 32 bits at byte addresses 0x000 to 0x3FF. The word index is address bits 9:2, and address bits 1:0 do not affect which word is read or written.
- R2: After a cycle with `rd_en` high, `rdata` shows the addressed value in the following cycle. `rdata` then keeps that value until the next read.
- R3: A read of 0x0000FFF8 returns input register 0, and a read of 0x0000FFFC returns input register 1.
- R4: A write to 0x0000FFFC loads `wdata` into `out_port` on that clock edge and leaves the RAM unchanged. A read of the same address still returns input register 1.
- R5: A button press with `sw_sel` low loads input register 0 with {23'b0, sw_data}. With `sw_sel` high it loads input register 1 the same way. The other register keeps its value.
- R6: One press loads the selected register exactly once, however long the button is held. Switch changes made while the button is still held are not taken.
- R7: `rst_n` low clears `out_port` and `rdata` to zero and does not change either input register.
- R8: A write to 0x0000FFF8, or to any address outside the RAM range and 0x0000FFFC, changes no state. A read of any address outside the RAM range and the two port addresses returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Processor reset, asynchronous assert, active low |
| addr | input | 32 | Byte address from the processor |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rdata | output | 32 | Read data, one cycle after the read strobe |
| sw_data | input | 9 | Shared data switches |
| sw_sel | input | 1 | Selects the input register to load (0 or 1) |
| load_btn | input | 1 | Raw load push-button |
| out_port | output | 32 | Output register |

## Verification
Every one of the 256 RAM words is written with a value derived arithmetically from its index and then read back. Aliasing through the low address bits is tried separately, which separates a correct bits-9:2 index from a shifted or truncated one. A spread of switch values is loaded into alternating registers, and both registers are read each time, which shows whether the selector, the zero extension or the hold of the unselected register is wrong. A long button press with the switches changing mid-press, a write to the input-only address, a write and a read outside the map, and a mid-run reset separate the single-load, ignore and reset-exemption rules from a design that only gets the common path right.

// File: rtl/mem_io_pkg.sv
package mem_io_pkg;
  localparam int unsigned BUS_W = 32;
  localparam logic [BUS_W-1:0] PORT_A_ADDR = 32'h0000_FFF8;
  localparam logic [BUS_W-1:0] PORT_B_ADDR = 32'h0000_FFFC;

  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_IN0  = 2'd1,
    RGN_IN1  = 2'd2,
    RGN_NONE = 2'd3
  } rgn_e;
endpackage

// File: rtl/mio_decode.sv
module mio_decode
  import mem_io_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  output rgn_e              rd_rgn,
  output logic              ram_we,
  output logic              out_we
);
  localparam int unsigned TOP_LO = IDX_W + 2;

  logic in_ram;

  always_comb begin
    in_ram = (addr[ADDR_W-1:TOP_LO] == '0);
    if (in_ram)                    rd_rgn = RGN_RAM;
    else if (addr == PORT_A_ADDR)  rd_rgn = RGN_IN0;
    else if (addr == PORT_B_ADDR)  rd_rgn = RGN_IN1;
    else                           rd_rgn = RGN_NONE;
    ram_we = wr_en & in_ram;
    out_we = wr_en & (addr == PORT_B_ADDR);
  end

  logic unused_rd;
  assign unused_rd = rd_en;
endmodule

// File: rtl/mio_ram.sv
module mio_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 256,
  parameter int unsigned IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              re,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rq
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rq <= mem[idx];
  end
endmodule

// File: rtl/mio_btn_edge.sv
module mio_btn_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic pulse
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], btn_raw};
    pulse  = sync_q[SYNC_STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end
endmodule

// File: rtl/mio_inports.sv
module mio_inports #(
  parameter int unsigned NPORT  = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SW_W   = 9,
  parameter int unsigned SEL_W  = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                          clk,
  input  logic                          load,
  input  logic [SEL_W-1:0]              sel,
  input  logic [SW_W-1:0]               sw,
  output logic [NPORT-1:0][DATA_W-1:0]  q
);
  logic [DATA_W-1:0] ext;

  always_comb ext = {{(DATA_W-SW_W){1'b0}}, sw};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic en;
    always_comb en = load & (sel == SEL_W'(p));
    always_ff @(posedge clk) begin
      if (en) q[p] <= ext;
    end
  end
endmodule

// File: rtl/mem_io_sys.sv
module mem_io_sys
  import mem_io_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RAM_WORDS = 256,
  parameter int unsigned SW_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [SW_W-1:0]   sw_data,
  input  logic              sw_sel,
  input  logic              load_btn,
  output logic [DATA_W-1:0] out_port
);
  localparam int unsigned IDX_W = $clog2(RAM_WORDS);
  localparam int unsigned NPORT = 2;

  rgn_e                        rd_rgn;
  logic                        ram_we, out_we;
  logic [DATA_W-1:0]           ram_q;
  logic                        load_pulse;
  logic [NPORT-1:0][DATA_W-1:0] in_q;
  logic [DATA_W-1:0]           in_port0, in_port1;

  rgn_e              sel_q, sel_d;
  logic [DATA_W-1:0] io_q, io_d;
  logic [DATA_W-1:0] out_q, out_d;

  mio_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .rd_rgn(rd_rgn), .ram_we(ram_we), .out_we(out_we)
  );

  mio_ram #(.DATA_W(DATA_W), .WORDS(RAM_WORDS), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .idx(addr[IDX_W+1:2]),
    .re(rd_en & (rd_rgn == RGN_RAM)), .we(ram_we),
    .wd(wdata), .rq(ram_q)
  );

  mio_btn_edge #(.SYNC_STAGES(2)) u_btn (
    .clk(clk), .rst_n(rst_n), .btn_raw(load_btn), .pulse(load_pulse)
  );

  mio_inports #(.NPORT(NPORT), .DATA_W(DATA_W), .SW_W(SW_W), .SEL_W(1)) u_in (
    .clk(clk), .load(load_pulse), .sel(sw_sel), .sw(sw_data), .q(in_q)
  );

  always_comb begin
    in_port0 = in_q[0];
    in_port1 = in_q[1];
    case (rd_rgn)
      RGN_IN0: io_d = in_port0;
      RGN_IN1: io_d = in_port1;
      default: io_d = '0;
    endcase
    sel_d = rd_en ? rd_rgn : sel_q;
    out_d = out_we ? wdata : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= RGN_NONE;
      io_q  <= '0;
      out_q <= '0;
    end else begin
      sel_q <= sel_d;
      if (rd_en) io_q <= io_d;
      out_q <= out_d;
    end
  end

  always_comb begin
    rdata    = (sel_q == RGN_RAM) ? ram_q : io_q;
    out_port = out_q;
  end

  logic [ADDR_W-1:0] unused_addr;
  assign unused_addr = addr;
endmodule

// File: rtl/mem_io_chk.sv
module mem_io_chk
  import mem_io_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SW_W   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] out_port,
  input logic [SW_W-1:0]   sw_data,
  input logic              sw_sel,
  input logic              load_pulse,
  input logic [DATA_W-1:0] in0,
  input logic [DATA_W-1:0] in1
);
  logic unmapped;
  always_comb unmapped = (addr[ADDR_W-1:10] != '0) && (addr != PORT_A_ADDR)
                         && (addr != PORT_B_ADDR);

  AST_OUT_TAKES_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PORT_B_ADDR) |=> out_port == $past(wdata)); // R4

  AST_OUT_CHANGES_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == PORT_B_ADDR)) |=> $stable(out_port)); // R8

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> rdata == '0); // R8

  AST_SINGLE_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse); // R6

  AST_LOAD_ZERO_EXT_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && !sw_sel) |=> in0 == {{(DATA_W-SW_W){1'b0}}, $past(sw_data)}); // R5

  AST_LOAD_ZERO_EXT_P1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && sw_sel) |=> in1 == {{(DATA_W-SW_W){1'b0}}, $past(sw_data)}); // R5

  AST_PORT_B_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == PORT_B_ADDR) |=> rdata == $past(in1)); // R3
endmodule

bind mem_io_sys mem_io_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SW_W(SW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
  .wr_en(wr_en), .rdata(rdata), .out_port(out_port), .sw_data(sw_data),
  .sw_sel(sw_sel), .load_pulse(load_pulse), .in0(in_port0), .in1(in_port1)
);

// File: tb/sim_mem_io_sys.sv
`timescale 1ns/1ps
module sim_mem_io_sys;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] addr, wdata, rdata, out_port;
  logic        rd_en, wr_en, sw_sel, load_btn;
  logic [8:0]  sw_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mem_io_sys u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .rdata(rdata), .sw_data(sw_data), .sw_sel(sw_sel),
    .load_btn(load_btn), .out_port(out_port)
  );

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'hA5A5_0000;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic press(input logic sel, input logic [8:0] v);
    @(negedge clk); sw_sel = sel; sw_data = v; load_btn = 1'b1;
    repeat (4) @(negedge clk);
    load_btn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, p0, p1;
    rst_n = 1'b0; addr = '0; wdata = '0; rd_en = 1'b0; wr_en = 1'b0;
    sw_data = '0; sw_sel = 1'b0; load_btn = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset out_port", out_port, 32'h0);
    check("R7 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: full sweep of the RAM
    for (int i = 0; i < 256; i++) wr(32'(i) << 2, pat(i));
    for (int i = 0; i < 256; i++) begin
      rd(32'(i) << 2, d);
      check("R1 ram word", d, pat(i));
    end
    // R1: low address bits ignored
    wr(32'h0000_0015, 32'h1234_5678);
    rd(32'h0000_0014, d); check("R1 alias write", d, 32'h1234_5678);
    rd(32'h0000_0017, d); check("R1 alias read", d, 32'h1234_5678);

    // R2: read data holds until the next read
    rd(32'h0000_0020, d);
    addr = 32'h0000_0040;
    repeat (3) @(negedge clk);
    check("R2 hold", rdata, pat(8));

    // R5 / R3: sweep switch values into alternating ports
    p0 = 32'h0; p1 = 32'h0;
    press(1'b0, 9'h000); press(1'b1, 9'h000);
    for (int v = 0; v < 512; v += 37) begin
      press(v[0], 9'(v ^ 9'h1AB));
      if (v[0]) p1 = 32'(9'(v ^ 9'h1AB)); else p0 = 32'(9'(v ^ 9'h1AB));
      rd(32'h0000_FFF8, d); check("R3 R5 port0", d, p0);
      rd(32'h0000_FFFC, d); check("R3 R5 port1", d, p1);
    end
    press(1'b0, 9'h1FF); p0 = 32'h1FF;
    rd(32'h0000_FFF8, d); check("R5 full switches zero-extended", d, 32'h0000_01FF);

    // R6: long press, switches changed while held
    @(negedge clk); sw_sel = 1'b1; sw_data = 9'h055; load_btn = 1'b1;
    repeat (5) @(negedge clk);
    sw_data = 9'h0AA;
    repeat (6) @(negedge clk);
    load_btn = 1'b0;
    repeat (3) @(negedge clk);
    p1 = 32'h055;
    rd(32'h0000_FFFC, d); check("R6 single load", d, p1);

    // R4: output register write
    wr(32'h0000_FFFC, 32'hCAFE_F00D);
    check("R4 out_port", out_port, 32'hCAFE_F00D);
    rd(32'h0000_FFFC, d); check("R4 read gives input reg 1", d, p1);
    rd(32'h0000_00FC, d); check("R4 ram untouched", d, pat(63));

    // R8: ignored writes and unmapped reads
    wr(32'h0000_FFF8, 32'hDEAD_BEEF);
    rd(32'h0000_FFF8, d); check("R8 port0 not writable", d, p0);
    check("R8 out_port unchanged", out_port, 32'hCAFE_F00D);
    wr(32'h0000_0400, 32'h0BAD_0BAD);
    rd(32'h0000_0000, d); check("R8 no wrap to word 0", d, pat(0));
    rd(32'h0000_0400, d); check("R8 unmapped read", d, 32'h0);
    rd(32'h8000_FFFC, d); check("R8 high bits unmapped", d, 32'h0);

    // R7: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 out_port cleared", out_port, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(32'h0000_FFF8, d); check("R7 port0 kept", d, p0);
    rd(32'h0000_FFFC, d); check("R7 port1 kept", d, p1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule